// File: doc/BRIEF.md
# Audio FIFO Pair Access Steering

This block sits between a host register bus and the two sample queues of a serial audio controller. It holds a transmit FIFO that the host fills and the serial shifter drains, and a receive FIFO that the shifter fills and the host drains. A control register holds the link enable, the bit-clock direction, a soft reset, two threshold fields and the two bits that steer host data accesses. The serial side is exposed as plain pop and push ports.

In normal mode the host may only push the transmit FIFO and only pop the receive FIFO. Setting the special-access bit lets the host push and pop one FIFO, chosen by the FIFO-select bit. This is useful for loopback and for testing the queues without a running serial link. A steering state machine follows the control bits. Its states are ST_NORMAL, ST_SPEC_TX (special access, transmit FIFO), ST_SPEC_RX (special access, receive FIFO) and ST_SOFTRST. Every cycle it moves to ST_SOFTRST when the soft-reset bit is 1. Otherwise it moves to ST_SPEC_RX or ST_SPEC_TX when special access is 1, depending on the select bit, and to ST_NORMAL when special access is 0. The state register follows a control write one clock later, so a changed mode applies to data accesses from the second clock edge after the write.

Host addresses are 0 for the control register, 1 for the transmit data port, 2 for the receive data port and 3 for a reserved address that reads zero. Host reads return data in the cycle after the read strobe.

Top module: `audio_fifo_steer`

## Requirements
- R1: After reset the control register reads 0x0000_7700, so both threshold fields hold 7. Both levels are 0, both error flags are 0, tx_empty is 1, tx_thr_flag is 1 and rx_thr_flag is 0.
- R2: Only control bits 0 (enable), 2 (bit-clock direction), 3 (soft reset), 4 (special access), 5 (FIFO select), 11:8 (transmit threshold) and 15:12 (receive threshold) are stored. All other bits read 0. Bit 0 drives link_enable. Bit 2 drives bclk_drive: 1 means the bit clock is driven out, and 0 means it comes from an external source.
- R3: In normal mode a host write to the transmit port pushes the transmit FIFO, which the shifter pops in order through tx_pop and tx_data. A host read of the receive port pops the oldest word that the shifter pushed.
- R4: In normal mode a host read of the transmit port returns 0 and does not pop. A host write to the receive port leaves the receive FIFO unchanged.
- R5: With special access 1 and select 0, host writes and reads of the transmit port push and pop the transmit FIFO in order. Accesses to the receive port are ignored, and reads of it return 0.
- R6: With special access 1 and select 1, host writes and reads of the receive port push and pop the receive FIFO in order. Accesses to the transmit port are ignored, and reads of it return 0.
- R7: While special access is 0, the select bit has no effect on steering.
- R8: A push to a full FIFO is dropped and sets that FIFO's sticky error flag. The flag stays set until a soft reset.
- R9: A pop from an empty FIFO is dropped and sets that FIFO's sticky error flag. A host read that pops an empty FIFO returns 0.
- R10: tx_thr_flag is 1 when the transmit level is at or below the transmit threshold. rx_thr_flag is 1 when the receive level is at or above the receive threshold.
- R11: While the soft-reset bit is 1, both FIFOs, both error flags and the read-data register are cleared, and data-port accesses are ignored. The control register keeps its value and stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 control, 1 transmit port, 2 receive port, 3 reserved |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_rd |
| tx_pop | input | 1 | Shifter pops the transmit FIFO |
| tx_data | output | 32 | Head of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_push | input | 1 | Shifter pushes the receive FIFO |
| rx_data | input | 32 | Word pushed by the shifter |
| rx_full | output | 1 | Receive FIFO full |
| tx_level | output | LVL_W | Transmit FIFO occupancy |
| rx_level | output | LVL_W | Receive FIFO occupancy |
| tx_thr_flag | output | 1 | Transmit level at or below its threshold |
| rx_thr_flag | output | 1 | Receive level at or above its threshold |
| tx_err | output | 1 | Sticky transmit overflow or underflow |
| rx_err | output | 1 | Sticky receive overflow or underflow |
| link_enable | output | 1 | Control bit 0 |
| bclk_drive | output | 1 | Control bit 2, bit clock driven out |

## Verification
The bench builds the block with FIFO_DEPTH set to 4, so each FIFO fills after four pushes. This puts the full and empty drops and the sticky error flags within a handful of accesses. With a depth of 4, threshold values of 1 and 2 also let both threshold flags change in both directions while the bench watches.

// File: rtl/audio_steer_pkg.sv
package audio_steer_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_SPEC_TX = 2'd1,
        ST_SPEC_RX = 2'd2,
        ST_SOFTRST = 2'd3
    } steer_state_e;

    // control bit positions
    localparam int CB_EN    = 0;
    localparam int CB_BCLK  = 2;
    localparam int CB_SRST  = 3;
    localparam int CB_SPEC  = 4;
    localparam int CB_SEL   = 5;
    localparam int TXT_LSB  = 8;
    localparam int RXT_LSB  = 12;
    localparam int THR_W    = 4;

    localparam logic [31:0] CTRL_RESET = 32'h0000_7700;
    localparam logic [31:0] CTRL_WMASK = 32'h0000_FF3D;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TXP  = 2'd1;
    localparam logic [1:0] ADDR_RXP  = 2'd2;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_TX   = 2'd1,
        RD_RX   = 2'd2
    } rd_src_e;

endpackage

// File: rtl/steer_fifo.sv
module steer_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             err
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            err    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            err    <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                level <= level + 1'b1;
            end else if (do_pop && !do_push) begin
                level <= level - 1'b1;
            end
            if ((push && full) || (pop && empty)) begin
                err <= 1'b1;
            end
        end
    end

    // R8
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (level == $past(level) && err));

    // R9
    drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (level == '0 && err));

endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
    import audio_steer_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         spec,
    input  logic         sel,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [1:0]   host_addr,
    output steer_state_e state,
    output logic         tx_host_push,
    output logic         tx_host_pop,
    output logic         rx_host_push,
    output logic         rx_host_pop,
    output rd_src_e      rd_src
);

    steer_state_e state_nx;
    logic wr_tx, wr_rx, rd_tx, rd_rx;

    assign wr_tx = host_wr && (host_addr == ADDR_TXP);
    assign wr_rx = host_wr && (host_addr == ADDR_RXP);
    assign rd_tx = host_rd && (host_addr == ADDR_TXP);
    assign rd_rx = host_rd && (host_addr == ADDR_RXP);

    always_comb begin
        if (srst) begin
            state_nx = ST_SOFTRST;
        end else if (spec) begin
            state_nx = sel ? ST_SPEC_RX : ST_SPEC_TX;
        end else begin
            state_nx = ST_NORMAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        tx_host_push = 1'b0;
        tx_host_pop  = 1'b0;
        rx_host_push = 1'b0;
        rx_host_pop  = 1'b0;
        rd_src       = RD_NONE;
        unique case (state)
            ST_NORMAL: begin
                tx_host_push = wr_tx;
                rx_host_pop  = rd_rx;
                if (rd_rx) rd_src = RD_RX;
            end
            ST_SPEC_TX: begin
                tx_host_push = wr_tx;
                tx_host_pop  = rd_tx;
                if (rd_tx) rd_src = RD_TX;
            end
            ST_SPEC_RX: begin
                rx_host_push = wr_rx;
                rx_host_pop  = rd_rx;
                if (rd_rx) rd_src = RD_RX;
            end
            ST_SOFTRST: begin
                rd_src = RD_NONE;
            end
        endcase
    end

    // R5 R6
    one_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((tx_host_push || tx_host_pop) && (rx_host_push || rx_host_pop)));

    // R4
    normal_no_txpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL) |-> !tx_host_pop && !rx_host_push);

endmodule

// File: rtl/audio_fifo_steer.sv
module audio_fifo_steer
    import audio_steer_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic             tx_pop,
    output logic [31:0]      tx_data,
    output logic             tx_empty,
    input  logic             rx_push,
    input  logic [31:0]      rx_data,
    output logic             rx_full,
    output logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] rx_level,
    output logic             tx_thr_flag,
    output logic             rx_thr_flag,
    output logic             tx_err,
    output logic             rx_err,
    output logic             link_enable,
    output logic             bclk_drive
);

    logic [31:0]  ctrl_q;
    steer_state_e state;
    rd_src_e      rd_src;
    logic         tx_host_push, tx_host_pop, rx_host_push, rx_host_pop;
    logic         fifo_clr, tx_full, rx_empty;
    logic [31:0]  rx_head, rx_push_data;
    logic [THR_W-1:0] tx_thr, rx_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (host_wr && host_addr == ADDR_CTRL) begin
            ctrl_q <= host_wdata & CTRL_WMASK;
        end
    end

    assign link_enable = ctrl_q[CB_EN];
    assign bclk_drive  = ctrl_q[CB_BCLK];
    assign tx_thr      = ctrl_q[TXT_LSB +: THR_W];
    assign rx_thr      = ctrl_q[RXT_LSB +: THR_W];

    steer_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .srst         (ctrl_q[CB_SRST]),
        .spec         (ctrl_q[CB_SPEC]),
        .sel          (ctrl_q[CB_SEL]),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_addr    (host_addr),
        .state        (state),
        .tx_host_push (tx_host_push),
        .tx_host_pop  (tx_host_pop),
        .rx_host_push (rx_host_push),
        .rx_host_pop  (rx_host_pop),
        .rd_src       (rd_src)
    );

    assign fifo_clr     = (state == ST_SOFTRST);
    assign rx_push_data = rx_push ? rx_data : host_wdata;

    steer_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (tx_host_push),
        .pop   (tx_pop || tx_host_pop),
        .wdata (host_wdata),
        .rdata (tx_data),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty),
        .err   (tx_err)
    );

    steer_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (rx_push || rx_host_push),
        .pop   (rx_host_pop),
        .wdata (rx_push_data),
        .rdata (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty),
        .err   (rx_err)
    );

    assign tx_thr_flag = (32'(tx_level) <= 32'(tx_thr));
    assign rx_thr_flag = (32'(rx_level) >= 32'(rx_thr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd && host_addr == ADDR_CTRL) begin
            host_rdata <= ctrl_q;
        end else if (fifo_clr) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            unique case (rd_src)
                RD_TX:   host_rdata <= tx_empty ? '0 : tx_data;
                RD_RX:   host_rdata <= rx_empty ? '0 : rx_head;
                default: host_rdata <= '0;
            endcase
        end
    end

    // R11
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFTRST) |=> (tx_level == '0 && rx_level == '0 && !tx_err && !rx_err));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == ADDR_CTRL) |=> $stable(ctrl_q));

    // R4
    tx_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && host_rd && host_addr == ADDR_TXP) |=> (host_rdata == '0));

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_RXP && rx_empty) |=> (host_rdata == '0));

endmodule

// File: tb/audio_fifo_steer_tb_top.sv
`timescale 1ns/1ps
module audio_fifo_steer_tb_top;

    localparam int DEPTH = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic tx_pop = 1'b0;
    logic [31:0] tx_data;
    logic tx_empty;
    logic rx_push = 1'b0;
    logic [31:0] rx_data = '0;
    logic rx_full;
    logic [LW-1:0] tx_level, rx_level;
    logic tx_thr_flag, rx_thr_flag, tx_err, rx_err, link_enable, bclk_drive;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    audio_fifo_steer #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr_flag(tx_thr_flag), .rx_thr_flag(rx_thr_flag),
        .tx_err(tx_err), .rx_err(rx_err),
        .link_enable(link_enable), .bclk_drive(bclk_drive)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        wr(2'd0, d);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sh_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic sh_push(input logic [31:0] d);
        @(negedge clk); rx_push = 1'b1; rx_data = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic soft_reset(input logic [31:0] base);
        wr_ctrl(base | 32'h8);
        wr_ctrl(base);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 tx_level", 32'(tx_level), 0);
        chk("R1 rx_level", 32'(rx_level), 0);
        chk("R1 errs", {30'd0, tx_err, rx_err}, 0);
        chk("R1 tx_empty", 32'(tx_empty), 1);
        chk("R1 flags", {30'd0, tx_thr_flag, rx_thr_flag}, 32'h2);
        rd(2'd0, v);
        chk("R1 ctrl reset", v, 32'h0000_7700);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        wr_ctrl(32'hFFFF_FFFF);
        rd(2'd0, v);
        chk("R2 mask", v, 32'h0000_FF3D);
        chk("R2 pins", {30'd0, link_enable, bclk_drive}, 32'h3);
        wr_ctrl(32'h0000_7700);
        chk("R2 pins off", {30'd0, link_enable, bclk_drive}, 0);
        rd(3'd3 & 2'd3, v);
        chk("R2 reserved addr", v, 0);
    endtask

    task automatic t_normal();
        logic [31:0] v;
        wr(2'd1, 32'hA1);
        wr(2'd1, 32'hB2);
        chk("R3 tx level", 32'(tx_level), 2);
        rd(2'd1, v);
        chk("R4 tx read zero", v, 0);
        chk("R4 tx not popped", 32'(tx_level), 2);
        chk("R3 tx head", tx_data, 32'hA1);
        sh_pop();
        chk("R3 tx second", tx_data, 32'hB2);
        sh_pop();
        chk("R3 tx drained", 32'(tx_empty), 1);
        sh_push(32'hC3);
        sh_push(32'hD4);
        wr(2'd2, 32'h99);
        chk("R4 rx write ignored", 32'(rx_level), 2);
        rd(2'd2, v);
        chk("R3 rx first", v, 32'hC3);
        rd(2'd2, v);
        chk("R3 rx second", v, 32'hD4);
    endtask

    task automatic t_spec_tx();
        logic [31:0] v;
        wr_ctrl(32'h0000_7710);
        wr(2'd1, 32'h11);
        wr(2'd1, 32'h22);
        rd(2'd1, v);
        chk("R5 tx pop first", v, 32'h11);
        rd(2'd1, v);
        chk("R5 tx pop second", v, 32'h22);
        chk("R5 tx level", 32'(tx_level), 0);
        sh_push(32'hE5);
        rd(2'd2, v);
        chk("R5 rx read zero", v, 0);
        wr(2'd2, 32'h77);
        chk("R5 rx untouched", 32'(rx_level), 1);
        soft_reset(32'h0000_7700);
    endtask

    task automatic t_spec_rx();
        logic [31:0] v;
        wr(2'd1, 32'h55);
        wr_ctrl(32'h0000_7730);
        wr(2'd2, 32'h33);
        wr(2'd2, 32'h44);
        chk("R6 rx level", 32'(rx_level), 2);
        rd(2'd2, v);
        chk("R6 rx pop first", v, 32'h33);
        rd(2'd2, v);
        chk("R6 rx pop second", v, 32'h44);
        rd(2'd1, v);
        chk("R6 tx read zero", v, 0);
        wr(2'd1, 32'h66);
        chk("R6 tx untouched", 32'(tx_level), 1);
        soft_reset(32'h0000_7700);
    endtask

    task automatic t_sel_noeffect();
        logic [31:0] v;
        wr_ctrl(32'h0000_7720);
        wr(2'd1, 32'h88);
        chk("R7 tx push", 32'(tx_level), 1);
        wr(2'd2, 32'h89);
        chk("R7 rx write ignored", 32'(rx_level), 0);
        rd(2'd1, v);
        chk("R7 tx read zero", v, 0);
        chk("R7 tx kept", 32'(tx_level), 1);
        soft_reset(32'h0000_7700);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH + 1; i++) wr(2'd1, 32'(i + 1));
        chk("R8 tx full level", 32'(tx_level), DEPTH);
        chk("R8 tx err", 32'(tx_err), 1);
        wr_ctrl(32'h0000_7701);
        chk("R8 err sticky", 32'(tx_err), 1);
        chk("R8 tx head", tx_data, 1);
        for (int i = 0; i < DEPTH + 1; i++) sh_push(32'(i));
        chk("R8 rx full", {30'd0, rx_full, rx_err}, 32'h3);
        soft_reset(32'h0000_7700);
        chk("R8 err cleared", {30'd0, tx_err, rx_err}, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        rd(2'd2, v);
        chk("R9 rx empty read", v, 0);
        chk("R9 rx err", 32'(rx_err), 1);
        chk("R9 rx level", 32'(rx_level), 0);
        wr_ctrl(32'h0000_7710);
        rd(2'd1, v);
        chk("R9 tx empty read", v, 0);
        chk("R9 tx err", 32'(tx_err), 1);
        soft_reset(32'h0000_7700);
    endtask

    task automatic t_thresh();
        wr_ctrl(32'h0000_2100);
        chk("R10 tx flag lvl0", 32'(tx_thr_flag), 1);
        wr(2'd1, 32'h1);
        chk("R10 tx flag lvl1", 32'(tx_thr_flag), 1);
        wr(2'd1, 32'h2);
        chk("R10 tx flag lvl2", 32'(tx_thr_flag), 0);
        sh_push(32'h3);
        chk("R10 rx flag lvl1", 32'(rx_thr_flag), 0);
        sh_push(32'h4);
        chk("R10 rx flag lvl2", 32'(rx_thr_flag), 1);
        soft_reset(32'h0000_7700);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        wr(2'd1, 32'hAB);
        sh_push(32'hCD);
        wr_ctrl(32'h0000_211D);
        chk("R11 levels cleared", {16'd0, 8'(tx_level), 8'(rx_level)}, 0);
        rd(2'd0, v);
        chk("R11 ctrl kept", v, 32'h0000_211D);
        wr(2'd1, 32'hEF);
        sh_push(32'h12);
        chk("R11 accesses ignored", {16'd0, 8'(tx_level), 8'(rx_level)}, 0);
        wr_ctrl(32'h0000_7700);
        chk("R11 released", 32'(tx_empty), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_mask();
        t_normal();
        t_spec_tx();
        t_spec_rx();
        t_sel_noeffect();
        t_overflow();
        t_underflow();
        t_thresh();
        t_srst();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule